// File: doc/BRIEF.md
# Streaming 17x17 Direct-Form Image Filter

This block applies a fixed two-dimensional 17-by-17 FIR kernel to a raster-scanned stream of 8-bit pixels. Sixteen image lines are delayed in shift-register line stores, and these form a 17x17 pixel window. Seventeen constant row filters, one per kernel row, each turn one window row into a partial sum using only shifts and adds. A pipelined adder tree then combines the partial sums, and the result is rounded and clamped to an 8-bit output pixel. Every accepted input pixel gives exactly one output pixel, in the same order, after a fixed latency.

The window is causal. The output for the pixel at line r, column c weighs the pixels at (r-i, c-j) for i and j in 0..16. Positions above the first line or left of the first column read as zero. Three states govern the input:
- `S_WAIT` waits for a frame after reset.
- `S_HEAD` means the next pixel opens a line.
- `S_BODY` means a line is in progress.

The transitions are:
- A pixel marked start-of-frame moves any state to `S_HEAD` if it also carries end-of-line, and otherwise to `S_BODY`.
- Any accepted pixel carrying end-of-line moves to `S_HEAD`.
- Any other accepted pixel moves to `S_BODY`.
- In `S_WAIT`, pixels without start-of-frame are dropped.

Top module: `flt2d_top`

## Requirements
- R1: After reset `out_valid` is 0, and it stays 0 until 5 clock edges after the first accepted pixel.
- R2: A pixel accepted on a rising edge produces `out_valid`=1 on the 5th rising edge after it (default parameters). There is one output per accepted pixel, in acceptance order.
- R3: The output before rounding is acc = sum over i,j in 0..16 of h(i,j)*x(r-i,c-j). Let d2=(i-8)^2+(j-8)^2. Then h is:
  - 32 for d2=0
  - 12 for d2<=4
  - 3 for d2<=16
  - -2 for d2<=40
  - 1 otherwise

  So kernel row k equals row 16-k (mirror pairs).
- R4: Pixels at r-i<0 or c-j<0 (above the frame top or left of the line start) contribute zero.
- R5: Rounding is floor((acc+64)/128).
- R6: The rounded value is clamped to 0..255: negative results give 0, results above 255 give 255.
- R7: Pixels with `in_valid`=1 arriving before the first start-of-frame after reset are dropped. They produce no output and have no effect on later frames.
- R8: A start-of-frame pixel, accepted in any state, starts a fresh frame. No pixel received before it influences its outputs. Outputs of earlier pixels still in the pipeline are delivered unchanged.
- R9: Each line carries exactly WIDTH pixels (default 24), and its last pixel has `in_eol`=1. The pixel after `in_eol` starts a new line, with the window columns to its left reading zero.
- R10: Cycles with `in_valid`=0 change neither the results nor their order.
- R11: A pixel with `in_valid`=1 and `in_sof`=1 always leaves the state machine out of `S_WAIT` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of its line |
| in_pix | input | 8 | Input pixel, unsigned |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 8 | Filtered pixel, unsigned |

## Verification
A start-of-frame clears the line stores and the window. That can fall in the same cycle in which the adder tree and the output stage still hold results of the previous frame. The bench provokes this by stopping a frame after three lines and sending the next frame's start-of-frame on the very next cycle. It then compares the full output stream against reference convolutions computed separately. The three partial lines of the old frame must match their own reference. The new frame must match a reference that starts from an all-zero history.

// File: rtl/flt2d_pkg.sv
package flt2d_pkg;

    typedef enum logic [1:0] {
        S_WAIT = 2'd0,
        S_HEAD = 2'd1,
        S_BODY = 2'd2
    } fstate_t;

    // circularly symmetric kernel weight at window position (i, j)
    function automatic int kcoef(input int i, input int j, input int k);
        int c;
        int d2;
        c  = k / 2;
        d2 = (i - c) * (i - c) + (j - c) * (j - c);
        if (d2 == 0)  return 32;
        if (d2 <= 4)  return 12;
        if (d2 <= 16) return 3;
        if (d2 <= 40) return -2;
        return 1;
    endfunction

    // n-th nonzero signed digit of the non-adjacent form of v
    function automatic int csd_sign(input int v, input int n);
        int r;
        int d;
        int cnt;
        int res;
        r   = v;
        cnt = 0;
        res = 0;
        for (int p = 0; p < 32; p++) begin
            if ((r & 1) != 0) begin
                d = ((r & 3) == 1) ? 1 : -1;
                r = r - d;
                if (cnt == n) res = d;
                cnt++;
            end
            r = r >>> 1;
        end
        return res;
    endfunction

    function automatic int csd_shift(input int v, input int n);
        int r;
        int d;
        int cnt;
        int res;
        r   = v;
        cnt = 0;
        res = 0;
        for (int p = 0; p < 32; p++) begin
            if ((r & 1) != 0) begin
                d = ((r & 3) == 1) ? 1 : -1;
                r = r - d;
                if (cnt == n) res = p;
                cnt++;
            end
            r = r >>> 1;
        end
        return res;
    endfunction

    // registered levels of an adder tree: every second level and the last
    function automatic int tree_stages(input int levels);
        int s;
        s = 0;
        for (int l = 1; l <= levels; l++)
            if ((l % 2 == 0) || (l == levels)) s++;
        return s;
    endfunction

endpackage

// File: rtl/flt2d_linebuf.sv
module flt2d_linebuf #(
    parameter int PIX_W = 8,
    parameter int WIDTH = 24,
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             clear,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] col [0:LINES]
);

    logic [PIX_W-1:0] mem [0:LINES-1][0:WIDTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++)
                for (int j = 0; j < WIDTH; j++)
                    mem[i][j] <= '0;
        end else if (shift) begin
            for (int i = 0; i < LINES; i++) begin
                for (int j = 0; j < WIDTH; j++) begin
                    if (clear)
                        mem[i][j] <= (i == 0 && j == 0) ? din : '0;
                    else if (j != 0)
                        mem[i][j] <= mem[i][j-1];
                    else if (i == 0)
                        mem[i][j] <= din;
                    else
                        mem[i][j] <= mem[i-1][WIDTH-1];
                end
            end
        end
    end

    always_comb begin
        col[0] = din;
        for (int i = 1; i <= LINES; i++)
            col[i] = clear ? '0 : mem[i-1][WIDTH-1];
    end

endmodule

// File: rtl/flt2d_row.sv
module flt2d_row
    import flt2d_pkg::*;
#(
    parameter int ROW   = 0,
    parameter int K     = 17,
    parameter int PIX_W = 8,
    parameter int ACC_W = 24,
    parameter int TERMS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PIX_W-1:0]        taps [0:K-1],
    output logic signed [ACC_W-1:0] sum_q
);

    logic signed [ACC_W-1:0] term [0:K-1][0:TERMS-1];
    logic signed [ACC_W-1:0] sum_c;

    for (genvar j = 0; j < K; j++) begin : g_tap
        logic signed [ACC_W-1:0] xe;
        assign xe = $signed({{(ACC_W-PIX_W){1'b0}}, taps[j]});
        for (genvar t = 0; t < TERMS; t++) begin : g_term
            localparam int SG = csd_sign(kcoef(ROW, j, K), t);
            localparam int SH = csd_shift(kcoef(ROW, j, K), t);
            if (SG > 0) begin : g_pos
                assign term[j][t] = xe <<< SH;
            end else if (SG < 0) begin : g_neg
                assign term[j][t] = -(xe <<< SH);
            end else begin : g_nil
                assign term[j][t] = '0;
            end
        end
    end

    always_comb begin
        sum_c = '0;
        for (int j = 0; j < K; j++)
            for (int t = 0; t < TERMS; t++)
                sum_c = sum_c + term[j][t];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_c;
    end

endmodule

// File: rtl/flt2d_tree.sv
module flt2d_tree #(
    parameter int N = 17,
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] din [0:N-1],
    output logic signed [W-1:0] dout
);

    localparam int L = $clog2(N);
    localparam int P = 1 << L;

    for (genvar l = 0; l <= L; l++) begin : g_lv
        localparam int CNT = P >> l;
        logic signed [W-1:0] node [0:CNT-1];
        if (l == 0) begin : g_leaf
            for (genvar n = 0; n < CNT; n++) begin : g_n
                if (n < N) begin : g_in
                    assign node[n] = din[n];
                end else begin : g_pad
                    assign node[n] = '0;
                end
            end
        end else if ((l % 2 == 0) || (l == L)) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int n = 0; n < CNT; n++) node[n] <= '0;
                end else begin
                    for (int n = 0; n < CNT; n++)
                        node[n] <= g_lv[l-1].node[2*n] + g_lv[l-1].node[2*n+1];
                end
            end
        end else begin : g_comb
            always_comb begin
                for (int n = 0; n < CNT; n++)
                    node[n] = g_lv[l-1].node[2*n] + g_lv[l-1].node[2*n+1];
            end
        end
    end

    assign dout = g_lv[L].node[0];

endmodule

// File: rtl/flt2d_top.sv
module flt2d_top
    import flt2d_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int WIDTH = 24,
    parameter int K     = 17,
    parameter int ACC_W = 24,
    parameter int SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int LINES   = K - 1;
    localparam int LEVELS  = $clog2(K);
    localparam int TREE_ST = tree_stages(LEVELS);
    localparam int LAT     = 2 + TREE_ST;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1 << (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

    fstate_t st_q, st_d;
    logic    pix_take, line_begin, frame_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_WAIT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_WAIT: if (in_valid && in_sof) st_d = in_eol ? S_HEAD : S_BODY;
            S_HEAD,
            S_BODY: if (in_valid)           st_d = in_eol ? S_HEAD : S_BODY;
            default:                        st_d = S_WAIT;
        endcase
    end

    // state outputs
    always_comb begin
        pix_take   = 1'b0;
        line_begin = 1'b0;
        frame_clr  = 1'b0;
        unique case (st_q)
            S_WAIT: begin
                pix_take   = in_valid && in_sof;
                line_begin = 1'b1;
                frame_clr  = 1'b1;
            end
            S_HEAD: begin
                pix_take   = in_valid;
                line_begin = 1'b1;
                frame_clr  = in_sof;
            end
            S_BODY: begin
                pix_take   = in_valid;
                line_begin = in_sof;
                frame_clr  = in_sof;
            end
            default: ;
        endcase
    end

    // line stores
    logic [PIX_W-1:0] col [0:LINES];

    flt2d_linebuf #(.PIX_W(PIX_W), .WIDTH(WIDTH), .LINES(LINES)) u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (pix_take),
        .clear (frame_clr),
        .din   (in_pix),
        .col   (col)
    );

    // pixel window: row i is line r-i, column j is pixel c-j
    logic [PIX_W-1:0] win [0:K-1][0:K-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < K; i++)
                for (int j = 0; j < K; j++)
                    win[i][j] <= '0;
        end else if (pix_take) begin
            for (int i = 0; i < K; i++)
                for (int j = 0; j < K; j++)
                    win[i][j] <= (j == 0) ? col[i] : (line_begin ? '0 : win[i][j-1]);
        end
    end

    // constant row filters
    logic signed [ACC_W-1:0] rsum [0:K-1];

    for (genvar i = 0; i < K; i++) begin : g_row
        flt2d_row #(.ROW(i), .K(K), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .taps  (win[i]),
            .sum_q (rsum[i])
        );
    end

    logic signed [ACC_W-1:0] total;

    flt2d_tree #(.N(K), .W(ACC_W)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rsum),
        .dout  (total)
    );

    // rounding and clamping
    logic signed [ACC_W-1:0] scaled;
    assign scaled = (total + RND) >>> SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              out_pix <= '0;
        else if (scaled < 0)     out_pix <= '0;
        else if (scaled > MAXV)  out_pix <= MAXV[PIX_W-1:0];
        else                     out_pix <= scaled[PIX_W-1:0];
    end

    // valid pipeline matching the data path
    logic [LAT:0] vpipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-1:0], pix_take};
    end

    assign out_valid = vpipe[LAT];

endmodule

// File: rtl/flt2d_chk.sv
module flt2d_chk
    import flt2d_pkg::*;
#(
    parameter int LAT = 5
) (
    input logic    clk,
    input logic    rst_n,
    input logic    in_valid,
    input logic    in_sof,
    input logic    out_valid,
    input fstate_t st,
    input logic    take
);

    int   since;
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= 0;
            seen  <= 1'b0;
        end else begin
            if (since <= LAT) since <= since + 1;
            if (in_valid && in_sof) seen <= 1'b1;
        end
    end

    // R1: silent until the pipeline can have filled
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since <= LAT) |-> !out_valid);

    // R2: output valid follows an accepted pixel by the fixed latency
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since > LAT) |-> (out_valid == $past(take, LAT + 1)));

    // R7: no output before any frame has started
    p_no_frame_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen);

    // R11: start-of-frame leaves the waiting state
    p_sof_leaves_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (st != S_WAIT));

endmodule

bind flt2d_top flt2d_chk #(.LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .st        (st_q),
    .take      (pix_take)
);

// File: tb/tb_flt2d_top.sv
module tb_flt2d_top;

    localparam int W   = 24;
    localparam int R   = 20;
    localparam int K   = 17;
    localparam int LAT = 5;
    localparam int MAXN = 4096;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sof, in_eol;
    logic [7:0] in_pix;
    logic       out_valid;
    logic [7:0] out_pix;

    always #2 clk = ~clk;

    flt2d_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    int img [0:R-1][0:W-1];
    int expv [0:MAXN-1];
    int got  [0:MAXN-1];
    int n_got;
    int n_chk;
    int n_err;
    bit done;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (n_got < MAXN) got[n_got] = int'(out_pix);
            n_got = n_got + 1;
        end
    end

    // kernel weight from the requirement text (R3)
    function automatic int kc(input int i, input int j);
        int d2;
        d2 = (i - 8) * (i - 8) + (j - 8) * (j - 8);
        if (d2 == 0)  return 32;
        if (d2 <= 4)  return 12;
        if (d2 <= 16) return 3;
        if (d2 <= 40) return -2;
        return 1;
    endfunction

    // reference: causal window, zero outside (R4), round (R5), clamp (R6)
    function automatic int ref_pix(input int r, input int c);
        int acc;
        int y;
        acc = 0;
        for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++)
                if (r - i >= 0 && c - j >= 0)
                    acc += kc(i, j) * img[r-i][c-j];
        y = (acc + 64) >>> 7;
        if (y < 0)   y = 0;
        if (y > 255) y = 255;
        return y;
    endfunction

    task automatic check(input int act, input int exp_val, input string tag);
        n_chk++;
        if (act != exp_val) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp_val);
        end
    endtask

    task automatic fill(input int kind);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < W; c++)
                case (kind)
                    0: img[r][c] = (r == 0 && c == 0) ? 255 : 0;
                    1: img[r][c] = (r * 13 + c * 7) % 256;
                    2: img[r][c] = 255;
                    3: img[r][c] = (r * 97 + c * 61 + r * c * 29 + 17) % 256;
                    default: img[r][c] = ((r + c) % 2 == 1) ? 240 : 10;
                endcase
    endtask

    task automatic build_exp(input int base, input int nrows);
        for (int r = 0; r < nrows; r++)
            for (int c = 0; c < W; c++)
                expv[base + r * W + c] = ref_pix(r, c);
    endtask

    task automatic idle_in();
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
        in_pix   = 8'd0;
    endtask

    task automatic drive_rows(input int nrows, input int gap);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_eol   = (c == W - 1);
                in_pix   = 8'(img[r][c]);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    idle_in();
                end
            end
        end
        @(negedge clk);
        idle_in();
    endtask

    task automatic drain();
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic compare(input int n, input string tag);
        check(n_got, n, {tag, " output count"});
        for (int k = 0; k < n; k++) check(got[k], expv[k], tag);
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_got = 0;
    endtask

    // R1: idle after reset
    task automatic t_reset();
        do_reset();
        repeat (8) begin
            @(negedge clk);
            check(int'(out_valid), 0, "R1 reset idle");
        end
    endtask

    // R2: exact latency of one accepted pixel
    task automatic t_latency();
        n_got = 0;
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b0; in_pix = 8'd200;
        @(negedge clk);
        idle_in();
        for (int d = 0; d < LAT; d++) begin
            check(int'(out_valid), 0, "R2 latency early");
            @(negedge clk);
        end
        check(int'(out_valid), 1, "R2 latency on time");
        @(negedge clk);
        check(int'(out_valid), 0, "R2 single output");
        drain();
        check(n_got, 1, "R2 one output per pixel");
    endtask

    // R7: pixels before a frame start are dropped; then R4/R6 impulse frame
    task automatic t_ignored_then_impulse();
        do_reset();
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0;
            in_eol = (k % 7 == 6); in_pix = 8'(100 + k);
        end
        @(negedge clk);
        idle_in();
        drain();
        check(n_got, 0, "R7 no output before frame");
        n_got = 0;
        fill(0);
        build_exp(0, R);
        drive_rows(R, 0);
        drain();
        compare(R * W, "R4/R6/R7/R9 impulse frame");
    endtask

    // R3/R5/R10: ramp with idle gaps between pixels
    task automatic t_ramp_gaps();
        n_got = 0;
        fill(1);
        build_exp(0, R);
        drive_rows(R, 2);
        drain();
        compare(R * W, "R3/R5/R10 ramp with gaps");
    endtask

    // R6: flat white saturates high
    task automatic t_white();
        n_got = 0;
        fill(2);
        build_exp(0, R);
        drive_rows(R, 0);
        drain();
        compare(R * W, "R6 white frame");
    endtask

    // R3/R9: two textured patterns
    task automatic t_texture();
        n_got = 0;
        fill(3);
        build_exp(0, R);
        drive_rows(R, 0);
        drain();
        compare(R * W, "R3/R9 texture frame");
        n_got = 0;
        fill(4);
        build_exp(0, R);
        drive_rows(R, 1);
        drain();
        compare(R * W, "R3/R5 checker frame");
    endtask

    // R8: abort after three lines, restart at once while outputs drain
    task automatic t_restart();
        n_got = 0;
        fill(2);
        build_exp(0, 3);
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_eol   = (c == W - 1);
                in_pix   = 8'(img[r][c]);
            end
        end
        fill(3);
        build_exp(3 * W, R);
        drive_rows(R, 0);
        drain();
        compare(3 * W + R * W, "R8 restart during drain");
    endtask

    initial begin
        n_chk = 0;
        n_err = 0;
        n_got = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        idle_in();
        t_reset();
        t_latency();
        t_ignored_then_impulse();
        t_ramp_gaps();
        t_white();
        t_texture();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule